// File: doc/BRIEF.md
# Asynchronous-Bus Static RAM Expansion Controller

This block lets a 512K x 8 static RAM sit as a slave on an 8-bit asynchronous bus of the 68000 family, which has 20 address lines. It watches the top two address bits and claims the two middle quarters of the 1 MB space, the quarters in which exactly one of those bits is high. When it sees its own address with the address strobe low, it drives a host-disable line at once, from the raw bus signals, so that the host's own memory decoder stays out of the cycle. An optional parameter also requires the two low function-code bits to differ before a cycle is claimed.

The bus strobes, read/write line, top address bits and function codes pass through a two-flop synchronizer. A three-state machine then runs the RAM. From `ST_IDLE`, a claim (both strobes low and address in the window) moves it to `ST_WAIT`. There it asserts chip-select, plus output-enable on reads or write-enable on writes, and counts a programmable number of clocks. From `ST_WAIT` the count reaching zero moves it to `ST_ACK`, where the acknowledge is driven low. From `ST_WAIT` or `ST_ACK`, the synchronized address strobe going high returns it to `ST_IDLE`. Acknowledge and host-disable are three-state outputs, each given as a value and an output-enable. The RAM address is bus bits 18..0 with no change, so both claimed quarters fold onto the same device.

Top module: `sram_exp_ctrl`

## Requirements
- R1: A cycle is claimed only when bus_addr[19] XOR bus_addr[18] is 1. With the bits 00 or 11, ram_cs_n stays 1 and ack_oe stays 0.
- R2: A claim needs both bus_as_n and bus_ds_n low. With only bus_as_n low, the RAM strobes and ack_oe stay released.
- R3: host_dis_oe is 1 in the same cycle, combinationally, whenever bus_as_n is low and the raw address (and the function codes, when that option is on) is in the window; otherwise it is 0. host_dis reads 1 whenever it is driven.
- R4: Three clock edges after a claim is applied, ram_cs_n goes low. ram_oe_n goes low only when bus_rw=1 (read) and ram_we_n only when bus_rw=0 (write); the other one stays 1.
- R5: ack_oe is 1 from the edge at which the RAM strobes start until release. ack_n stays 1 (not ready) during the access wait.
- R6: ack_n goes low exactly WAIT_CLKS edges after the RAM strobes start, where WAIT_CLKS = max(1, ceil(ACCESS_PS / CLK_PERIOD_PS)). This is 13 at the defaults (50000 ps, 4000 ps).
- R7: After bus_as_n rises, the strobes and ack_oe are still held at the second edge. At the third edge ram_cs_n, ram_oe_n and ram_we_n are all 1 and ack_oe is 0.
- R8: A new cycle that starts straight after a release is claimed with the same three-edge latency.
- R9: With USE_FC=1, a claim also needs bus_fc[0] XOR bus_fc[1] = 1.
- R10: ram_addr always equals bus_addr[18:0].
- R11: After reset, ram_cs_n, ram_oe_n and ram_we_n are 1, and ack_oe and host_dis_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 20 | Bus address, bit 19 most significant |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds_n | input | 1 | Data strobe, active low |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_fc | input | 2 | Function-code bits 1..0 |
| ram_addr | output | 19 | RAM address |
| ram_cs_n | output | 1 | RAM chip-select, active low |
| ram_oe_n | output | 1 | RAM output-enable, active low |
| ram_we_n | output | 1 | RAM write-enable, active low |
| ack_n | output | 1 | Acknowledge value, active low |
| ack_oe | output | 1 | Acknowledge pin drive enable |
| host_dis | output | 1 | Host-decoder-disable value |
| host_dis_oe | output | 1 | Host-decoder-disable drive enable |

## Verification
host_dis_oe and ram_addr are combinational, so they are sampled one nanosecond after the inputs change. The RAM strobes and ack_oe appear three edges after a stimulus: two synchronizer flops and the state register. ack_n falls WAIT_CLKS edges after that. All these outputs are released three edges after bus_as_n rises. The bench drives inputs on falling edges and counts rising edges to each due edge. It samples at the next falling edge, and it also samples one edge early, to show that nothing is released or acknowledged too soon.

// File: rtl/sram_exp_pkg.sv
package sram_exp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } ctrl_state_t;

    function automatic int calc_wait_clks(input int access_ps, input int period_ps);
        int n;
        n = (access_ps + period_ps - 1) / period_ps;
        return (n < 1) ? 1 : n;
    endfunction
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int          WIDTH   = 7,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[i] <= RST_VAL[i];
                q_sync[i] <= RST_VAL[i];
            end else begin
                stage1[i] <= d_async[i];
                q_sync[i] <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/window_decode.sv
module window_decode #(
    parameter bit USE_FC = 1'b0
) (
    input  logic       a19,
    input  logic       a18,
    input  logic [1:0] fc,
    output logic       in_window
);
    logic fc_ok;
    assign fc_ok     = USE_FC ? (fc[0] ^ fc[1]) : 1'b1;
    assign in_window = (a19 ^ a18) & fc_ok;
endmodule

// File: rtl/sram_exp_ctrl.sv
module sram_exp_ctrl
    import sram_exp_pkg::*;
#(
    parameter int ACCESS_PS     = 50000,
    parameter int CLK_PERIOD_PS = 4000,
    parameter bit USE_FC        = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [19:0] bus_addr,
    input  logic        bus_as_n,
    input  logic        bus_ds_n,
    input  logic        bus_rw,
    input  logic [1:0]  bus_fc,
    output logic [18:0] ram_addr,
    output logic        ram_cs_n,
    output logic        ram_oe_n,
    output logic        ram_we_n,
    output logic        ack_n,
    output logic        ack_oe,
    output logic        host_dis,
    output logic        host_dis_oe
);
    localparam int WAIT_CLKS = calc_wait_clks(ACCESS_PS, CLK_PERIOD_PS);
    localparam int CW        = $clog2(WAIT_CLKS + 1);
    localparam int SW        = 7;

    // synchronized copies of the asynchronous bus controls
    logic [SW-1:0] raw_bus, syn_bus;
    logic          a19_s, a18_s, rw_s, as_n_s, ds_n_s;
    logic [1:0]    fc_s;

    assign raw_bus = {bus_addr[19], bus_addr[18], bus_fc, bus_rw, bus_as_n, bus_ds_n};
    assign {a19_s, a18_s, fc_s, rw_s, as_n_s, ds_n_s} = syn_bus;

    bus_sync #(.WIDTH(SW), .RST_VAL('1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_bus),
        .q_sync  (syn_bus)
    );

    // fast decode from raw pins drives the host-disable line
    logic win_raw, win_s;

    window_decode #(.USE_FC(USE_FC)) u_dec_raw (
        .a19       (bus_addr[19]),
        .a18       (bus_addr[18]),
        .fc        (bus_fc),
        .in_window (win_raw)
    );

    window_decode #(.USE_FC(USE_FC)) u_dec_syn (
        .a19       (a19_s),
        .a18       (a18_s),
        .fc        (fc_s),
        .in_window (win_s)
    );

    assign host_dis_oe = win_raw & ~bus_as_n;
    assign host_dis    = host_dis_oe;
    assign ram_addr    = bus_addr[18:0];

    logic claim_s;
    assign claim_s = win_s & ~as_n_s & ~ds_n_s;

    // state register and wait counter
    ctrl_state_t    state, state_nx;
    logic [CW-1:0]  wait_cnt, wait_cnt_nx;

    always_comb begin
        state_nx    = state;
        wait_cnt_nx = wait_cnt;
        unique case (state)
            ST_IDLE: begin
                if (claim_s) begin
                    state_nx    = ST_WAIT;
                    wait_cnt_nx = CW'(WAIT_CLKS - 1);
                end
            end
            ST_WAIT: begin
                if (as_n_s)              state_nx = ST_IDLE;
                else if (wait_cnt == '0) state_nx = ST_ACK;
                else                     wait_cnt_nx = wait_cnt - 1'b1;
            end
            ST_ACK: begin
                if (as_n_s) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
        end else begin
            state    <= state_nx;
            wait_cnt <= wait_cnt_nx;
        end
    end

    // outputs from state
    always_comb begin
        ram_cs_n = 1'b1;
        ram_oe_n = 1'b1;
        ram_we_n = 1'b1;
        ack_n    = 1'b1;
        ack_oe   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_WAIT: begin
                ram_cs_n = 1'b0;
                ram_oe_n = ~rw_s;
                ram_we_n = rw_s;
                ack_oe   = 1'b1;
            end
            ST_ACK: begin
                ram_cs_n = 1'b0;
                ram_oe_n = ~rw_s;
                ram_we_n = rw_s;
                ack_oe   = 1'b1;
                ack_n    = 1'b0;
            end
            default: ;
        endcase
    end

    // checker: length of the current chip-select run, saturating
    logic [CW-1:0] cs_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cs_run <= '0;
        else if (ram_cs_n)                 cs_run <= '0;
        else if (cs_run != CW'(WAIT_CLKS)) cs_run <= cs_run + 1'b1;
    end

    // R6
    ack_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_oe && !ack_n) |-> (cs_run >= CW'(WAIT_CLKS)));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cs_n |-> (ram_oe_n != ram_we_n));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (as_n_s && state != ST_IDLE) |=> (ram_cs_n && !ack_oe));

    // R1
    window_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_cs_n) |-> $past(win_s));

    // R3
    host_dis_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_dis_oe |-> !bus_as_n);

    // R5
    ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cs_n |-> ack_oe);
endmodule

// File: tb/sram_exp_ctrl_test.sv
module sram_exp_ctrl_test;
    localparam int W = 13;  // ceil(50000 / 4000)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_as_n = 1'b1;
    logic        bus_ds_n = 1'b1;
    logic        bus_rw = 1'b1;
    logic [1:0]  bus_fc = 2'b00;

    logic [18:0] ram_addr, f_addr;
    logic ram_cs_n, ram_oe_n, ram_we_n, ack_n, ack_oe, host_dis, host_dis_oe;
    logic f_cs_n, f_oe_n, f_we_n, f_ack_n, f_ack_oe, f_dis, f_dis_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sram_exp_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_as_n(bus_as_n),
        .bus_ds_n(bus_ds_n), .bus_rw(bus_rw), .bus_fc(bus_fc),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .ack_n(ack_n), .ack_oe(ack_oe),
        .host_dis(host_dis), .host_dis_oe(host_dis_oe)
    );

    sram_exp_ctrl #(.USE_FC(1'b1)) uut_fc (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_as_n(bus_as_n),
        .bus_ds_n(bus_ds_n), .bus_rw(bus_rw), .bus_fc(bus_fc),
        .ram_addr(f_addr), .ram_cs_n(f_cs_n), .ram_oe_n(f_oe_n),
        .ram_we_n(f_we_n), .ack_n(f_ack_n), .ack_oe(f_ack_oe),
        .host_dis(f_dis), .host_dis_oe(f_dis_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // fields: a19 a18 | fc[1:0] | rw | claim (plain) | claim (fc option)
    localparam int NV = 8;
    localparam logic [6:0] VEC [NV] = '{
        7'b00_01_1_0_0,
        7'b01_01_1_1_1,
        7'b10_10_0_1_1,
        7'b11_01_1_0_0,
        7'b01_11_0_1_0,
        7'b10_00_1_1_0,
        7'b01_10_0_1_1,
        7'b10_01_0_1_1
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R11 reset state
        edges(3);
        chk("R11 cs_n", 32'(ram_cs_n), 1);
        chk("R11 oe/we", 32'({ram_oe_n, ram_we_n}), 2'b11);
        chk("R11 ack_oe", 32'(ack_oe), 0);
        chk("R11 host_dis_oe", 32'(host_dis_oe), 0);
        rst_n = 1'b1;
        edges(2);

        for (int i = 0; i < NV; i++) begin
            logic [6:0] v;
            logic [17:0] low;
            v = VEC[i];
            low = 18'h12345 ^ 18'(i * 18'h0A5F3);
            bus_addr = {v[6:5], low};
            bus_fc   = v[4:3];
            bus_rw   = v[2];
            bus_as_n = 1'b0;
            bus_ds_n = 1'b0;
            #1;
            chk("R3 host_dis_oe", 32'(host_dis_oe), 32'(v[1]));
            chk("R9 host_dis_oe fc", 32'(f_dis_oe), 32'(v[0]));
            if (v[1]) chk("R3 host_dis value", 32'(host_dis), 1);
            chk("R10 ram_addr", 32'(ram_addr), 32'({v[5], low}));
            edges(2);
            chk("R4 cs_n before edge 3", 32'(ram_cs_n), 1);
            edges(1);
            chk("R1 cs_n", 32'(ram_cs_n), 32'(!v[1]));
            chk("R9 cs_n fc", 32'(f_cs_n), 32'(!v[0]));
            chk("R5 ack_oe", 32'(ack_oe), 32'(v[1]));
            if (v[1]) begin
                chk("R4 oe_n", 32'(ram_oe_n), 32'(!v[2]));
                chk("R4 we_n", 32'(ram_we_n), 32'(v[2]));
                chk("R5 ack_n waiting", 32'(ack_n), 1);
            end
            edges(W - 1);
            if (v[1]) chk("R6 ack_n one edge early", 32'(ack_n), 1);
            edges(1);
            chk("R6 ack asserted", 32'(ack_oe && !ack_n), 32'(v[1]));
            bus_as_n = 1'b1;
            bus_ds_n = 1'b1;
            edges(2);
            chk("R7 held at edge 2", 32'(!ram_cs_n), 32'(v[1]));
            edges(1);
            chk("R7 released", 32'({ram_cs_n, ram_oe_n, ram_we_n, ack_oe}), 4'b1110);
        end

        // R2: address strobe only, data strobe stays high
        bus_addr = 20'h40010;
        bus_rw   = 1'b1;
        bus_as_n = 1'b0;
        #1;
        chk("R2 host_dis_oe with AS only", 32'(host_dis_oe), 1);
        edges(W + 4);
        chk("R2 no strobes", 32'({ram_cs_n, ram_oe_n, ram_we_n}), 3'b111);
        chk("R2 no ack drive", 32'(ack_oe), 0);
        bus_as_n = 1'b1;
        edges(4);

        // R8: back-to-back write then read
        bus_addr = 20'h80001;
        bus_rw   = 1'b0;
        bus_as_n = 1'b0;
        bus_ds_n = 1'b0;
        edges(3 + W);
        chk("R8 first ack", 32'(ack_n), 0);
        bus_as_n = 1'b1;
        bus_ds_n = 1'b1;
        edges(3);
        chk("R8 first released", 32'(ram_cs_n), 1);
        bus_addr = 20'h7FFFF;
        bus_rw   = 1'b1;
        bus_as_n = 1'b0;
        bus_ds_n = 1'b0;
        edges(3);
        chk("R8 second cs_n", 32'(ram_cs_n), 0);
        chk("R8 second oe_n", 32'(ram_oe_n), 0);
        edges(W);
        chk("R8 second ack", 32'(ack_n), 0);
        bus_as_n = 1'b1;
        bus_ds_n = 1'b1;
        edges(3);
        chk("R7 released after back-to-back", 32'(ack_oe), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule